// File: doc/BRIEF.md
# Eight-bit ALU with Status Register

This block is the arithmetic and logic datapath of a small 8-bit RISC core. It combines two byte operands with the carry held in its own status register and returns the byte result in the same cycle. It also returns the merged next status value and an eight-bit mask of the flags that the selected operation writes. When the core asserts `op_valid`, the masked flags are loaded into the status register at the next clock edge. Every flag outside the mask keeps its value.

The operation set covers the following groups:
- add and subtract, each with and without carry-in;
- AND, OR and XOR;
- one's complement and two's-complement negate;
- increment and decrement;
- logical shifts, arithmetic right shift, and rotates through carry;
- nibble swap;
- a 16-bit add or subtract of a small unsigned immediate on a register pair.

Instruction decode, the register file and memory access are outside the block. The caller presents the operands it has already read.

Top module: `alu8_status`

## Requirements
- R1: The status register bit layout is I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0, and it resets to 0x00. On a clock edge with `op_valid` high, only the bits set in `flag_wr` take their value from `status_next`. With `op_valid` low, the status register does not change.
- R2: ADD (code 0) and ADC (code 1) return a+b, or a+b+C for ADC. They write Z, C, N, V, H and S. C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R3: SUB (code 2) and SBC (code 3) return a-b, or a-b-C for SBC. They write Z, C, N, V, H and S. C is the borrow out of bit 7 and H is the borrow out of bit 3.
- R4: For SBC, Z becomes 0 if the result is nonzero. If the result is zero, Z keeps its previous value.
- R5: AND (code 4), OR (code 5) and XOR (code 6) write Z, N, S and V, with V forced to 0. C and H are unchanged.
- R6: COM (code 7) returns the bitwise inverse of a. It sets C to 1 and V to 0, and writes Z, N and S.
- R7: NEG (code 8) returns 0-a. C is 1 for a nonzero result, V is 1 only for a result of 0x80, and H is the borrow out of bit 3. The operation also writes Z, N and S.
- R8: INC (code 9) and DEC (code 10) return a+1 and a-1 and write Z, N, V and S only. V is 1 for 0x7F to 0x80 (INC) and for 0x80 to 0x7F (DEC). C and H are unchanged.
- R9: LSL (code 11) shifts left with 0 into bit 0 and bit 7 into C. LSR (code 12) shifts right with 0 into bit 7 and bit 0 into C. ASR (code 15) shifts right with bit 7 kept and bit 0 into C.
- R10: ROL (code 13) moves C into bit 0 and bit 7 into C. ROR (code 14) moves C into bit 7 and bit 0 into C.
- R11: Every shift and rotate writes Z, C, N, V and S, with V equal to N XOR C after the operation. H is unchanged.
- R12: SWAP (code 16) exchanges the two nibbles of a and writes no flag. Codes 17 to 31 that are not defined return 0 and write no flag.
- R13: WADD (code 17) and WSUB (code 18) add or subtract the immediate `opnd_b[IMM_W-1:0]` on the pair {`pair_hi`, `opnd_a`}; the higher bits of `opnd_b` are ignored. The result appears on {`result_hi`, `result`}. The operation writes Z over 16 bits, C as carry or borrow out of bit 15, N as bit 15, V as signed overflow, and S; H is unchanged. For all byte operations, `result_hi` is 0.
- R14: Whenever N or V is written, S is written with the new N XOR V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Commit the masked flags at the next edge |
| op_code | input | 5 | Operation select |
| opnd_a | input | 8 | First operand, low byte of the pair for word operations |
| opnd_b | input | 8 | Second operand, immediate in its low IMM_W bits for word operations |
| pair_hi | input | 8 | High byte of the register pair |
| result | output | 8 | Byte result, low byte of the word result |
| result_hi | output | 8 | High byte of the word result, 0 otherwise |
| flag_wr | output | 8 | Flags written by the selected operation |
| status_next | output | 8 | Status value that the next committing edge loads |
| status | output | 8 | Current status register |

## Verification
`result`, `result_hi`, `flag_wr` and `status_next` are combinational. The bench therefore reads them one nanosecond after it changes the inputs at a falling edge, before the next rising edge. `status` is loaded by that rising edge and is read one nanosecond after it, so each flag check lands exactly one register stage after the operation. Carry-in and the previous Z come from the register, so every vector is preceded by a committed setup operation that puts the status into a known state: either 0x00 or 0x35.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DW  = 8;
    localparam int WW  = 2 * DW;
    localparam int NIB = DW / 2;

    typedef enum logic [4:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_COM  = 5'd7,
        OP_NEG  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_LSL  = 5'd11,
        OP_LSR  = 5'd12,
        OP_ROL  = 5'd13,
        OP_ROR  = 5'd14,
        OP_ASR  = 5'd15,
        OP_SWAP = 5'd16,
        OP_WADD = 5'd17,
        OP_WSUB = 5'd18
    } op_e;

    // packed so that field order equals bit order 7..0
    typedef struct packed {
        logic i;
        logic t;
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } sreg_t;

    localparam sreg_t WE_NONE   = sreg_t'(8'h00);
    localparam sreg_t WE_ARITH  = sreg_t'(8'h3F); // H S V N Z C
    localparam sreg_t WE_LOGIC  = sreg_t'(8'h1E); // S V N Z
    localparam sreg_t WE_SHIFT  = sreg_t'(8'h1F); // S V N Z C
    localparam sreg_t WE_STEP   = sreg_t'(8'h1E); // S V N Z
    localparam sreg_t WE_WORD   = sreg_t'(8'h1F); // S V N Z C

    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        sreg_t         flg;
        sreg_t         we;
    } alu_out_t;

    // builds a flag set with S tied to N xor V
    function automatic sreg_t mk_flags(input logic n, input logic v,
                                       input logic z, input logic c,
                                       input logic h);
        sreg_t f;
        f   = '0;
        f.n = n;
        f.v = v;
        f.z = z;
        f.c = c;
        f.h = h;
        f.s = n ^ v;
        return f;
    endfunction

    function automatic sreg_t merge_flags(input sreg_t cur, input sreg_t nxt,
                                          input sreg_t we);
        return (cur & ~we) | (nxt & we);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W  = 8,
    parameter int HB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         co,
    output logic         hc,
    output logic         ov
);
    logic [W:0]   cy;
    logic [W-1:0] bx;

    // subtraction as a + ~b + ~borrow_in
    assign bx    = sub ? ~b : b;
    assign cy[0] = sub ? ~cin : cin;

    generate
        for (genvar k = 0; k < W; k++) begin : g_bit
            assign r[k]    = a[k] ^ bx[k] ^ cy[k];
            assign cy[k+1] = (a[k] & bx[k]) | (cy[k] & (a[k] ^ bx[k]));
        end
    endgenerate

    // carries invert to borrows when subtracting
    assign co = sub ? ~cy[W]  : cy[W];
    assign hc = sub ? ~cy[HB] : cy[HB];
    assign ov = cy[W] ^ cy[W-1];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);
    localparam int HW = W / 2;

    always_comb begin
        case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  r = ~a;
            OP_SWAP: r = {a[HW-1:0], a[W-1:HW]};
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] r,
    output logic         co
);
    always_comb begin
        r  = '0;
        co = 1'b0;
        case (op)
            OP_LSL: begin r = {a[W-2:0], 1'b0};   co = a[W-1]; end
            OP_LSR: begin r = {1'b0, a[W-1:1]};   co = a[0];   end
            OP_ASR: begin r = {a[W-1], a[W-1:1]}; co = a[0];   end
            OP_ROL: begin r = {a[W-2:0], cin};    co = a[W-1]; end
            OP_ROR: begin r = {cin, a[W-1:1]};    co = a[0];   end
            default: begin r = '0; co = 1'b0; end
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu_pkg::*;
#(
    parameter int IMM_W = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [4:0]  op_code,
    input  logic [7:0]  opnd_a,
    input  logic [7:0]  opnd_b,
    input  logic [7:0]  pair_hi,
    output logic [7:0]  result,
    output logic [7:0]  result_hi,
    output logic [7:0]  flag_wr,
    output logic [7:0]  status_next,
    output logic [7:0]  status
);
    op_e      op;
    sreg_t    st_q;
    sreg_t    st_d;
    alu_out_t o;

    assign op = op_e'(op_code);

    // byte adder/subtractor shared by add, sub, neg, inc, dec
    logic [DW-1:0] as_a, as_b, as_r;
    logic          as_cin, as_sub, as_co, as_hc, as_ov;

    always_comb begin
        as_a   = opnd_a;
        as_b   = opnd_b;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (op)
            OP_ADC: as_cin = st_q.c;
            OP_SUB: as_sub = 1'b1;
            OP_SBC: begin as_sub = 1'b1; as_cin = st_q.c; end
            OP_NEG: begin as_sub = 1'b1; as_a = '0; as_b = opnd_a; end
            OP_INC: as_b = DW'(1);
            OP_DEC: begin as_sub = 1'b1; as_b = DW'(1); end
            default: ;
        endcase
    end

    alu_addsub #(.W(DW), .HB(NIB)) u_byte (
        .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
        .r(as_r), .co(as_co), .hc(as_hc), .ov(as_ov)
    );

    logic [DW-1:0] lg_r;
    alu_logic #(.W(DW)) u_logic (.op(op), .a(opnd_a), .b(opnd_b), .r(lg_r));

    logic [DW-1:0] sh_r;
    logic          sh_co;
    alu_shift #(.W(DW)) u_shift (.op(op), .a(opnd_a), .cin(st_q.c),
                                 .r(sh_r), .co(sh_co));

    // word path on the register pair
    logic [WW-1:0] w_pair, w_imm, w_r;
    logic          w_co, w_hc, w_ov;

    assign w_pair = {pair_hi, opnd_a};
    assign w_imm  = WW'(opnd_b[IMM_W-1:0]);

    alu_addsub #(.W(WW), .HB(NIB)) u_word (
        .a(w_pair), .b(w_imm), .cin(1'b0), .sub(op == OP_WSUB),
        .r(w_r), .co(w_co), .hc(w_hc), .ov(w_ov)
    );

    always_comb begin
        o.hi  = '0;
        o.lo  = '0;
        o.flg = '0;
        o.we  = WE_NONE;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
                o.lo  = as_r;
                o.flg = mk_flags(as_r[DW-1], as_ov, as_r == '0, as_co, as_hc);
                o.we  = WE_ARITH;
            end
            OP_SBC: begin
                o.lo  = as_r;
                o.flg = mk_flags(as_r[DW-1], as_ov, (as_r == '0) & st_q.z,
                                 as_co, as_hc);
                o.we  = WE_ARITH;
            end
            OP_INC, OP_DEC: begin
                o.lo  = as_r;
                o.flg = mk_flags(as_r[DW-1], as_ov, as_r == '0, 1'b0, 1'b0);
                o.we  = WE_STEP;
            end
            OP_AND, OP_OR, OP_XOR: begin
                o.lo  = lg_r;
                o.flg = mk_flags(lg_r[DW-1], 1'b0, lg_r == '0, 1'b0, 1'b0);
                o.we  = WE_LOGIC;
            end
            OP_COM: begin
                o.lo  = lg_r;
                o.flg = mk_flags(lg_r[DW-1], 1'b0, lg_r == '0, 1'b1, 1'b0);
                o.we  = WE_SHIFT;
            end
            OP_SWAP: begin
                o.lo = lg_r;
            end
            OP_LSL, OP_LSR, OP_ASR, OP_ROL, OP_ROR: begin
                o.lo  = sh_r;
                o.flg = mk_flags(sh_r[DW-1], sh_r[DW-1] ^ sh_co, sh_r == '0,
                                 sh_co, 1'b0);
                o.we  = WE_SHIFT;
            end
            OP_WADD, OP_WSUB: begin
                o.hi  = w_r[WW-1:DW];
                o.lo  = w_r[DW-1:0];
                o.flg = mk_flags(w_r[WW-1], w_ov, w_r == '0, w_co, w_hc);
                o.we  = WE_WORD;
            end
            default: ;
        endcase
    end

    assign st_d = merge_flags(st_q, o.flg, o.we);

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (op_valid)
            st_q <= st_d;
    end

    assign result      = o.lo;
    assign result_hi   = o.hi;
    assign flag_wr     = o.we;
    assign status_next = st_d;
    assign status      = st_q;
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
    import alu_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [4:0] op_code,
    input logic [7:0] result,
    input logic [7:0] result_hi,
    input logic [7:0] flag_wr,
    input logic [7:0] status
);
    logic is_logic, is_step, is_word;
    assign is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
    assign is_step  = (op_code == OP_INC) || (op_code == OP_DEC);
    assign is_word  = (op_code == OP_WADD) || (op_code == OP_WSUB);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> status == $past(status));

    assert_sign_flag_R14: assert property (@(posedge clk) disable iff (rst)
        status[4] == (status[3] ^ status[2]));

    assert_step_keeps_c_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_step) |=> status[0] == $past(status[0]));

    assert_logic_clears_v_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_logic) |=> !status[3]);

    assert_sbc_z_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_SBC && result != 8'h00) |=> !status[1]);

    assert_swap_no_flags_R12: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_SWAP) |-> flag_wr == 8'h00);

    assert_rol_carry_in_R10: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ROL) |-> result[0] == status[0]);

    assert_byte_hi_zero_R13: assert property (@(posedge clk) disable iff (rst)
        !is_word |-> result_hi == 8'h00);
endmodule

bind alu8_status alu8_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .result    (result),
    .result_hi (result_hi),
    .flag_wr   (flag_wr),
    .status    (status)
);

// File: tb/tb_alu8_status.sv
`timescale 1ns/1ps
module tb_alu8_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [4:0] op_code = '0;
    logic [7:0] opnd_a = '0, opnd_b = '0, pair_hi = '0;
    logic [7:0] result, result_hi, flag_wr, status_next, status;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] cap_res, cap_hi, cap_next, cap_st;

    always #2.5 clk = ~clk;

    alu8_status dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .pair_hi(pair_hi),
        .result(result), .result_hi(result_hi), .flag_wr(flag_wr),
        .status_next(status_next), .status(status)
    );

    // {op, setup, a, b, hi, exp_result, exp_hi, exp_status}
    // setup 0 commits status 0x00, setup 1 commits status 0x35 (H S N C)
    localparam int NV = 27;
    localparam logic [53:0] VECS [0:NV-1] = '{
        {5'd0,  1'b0, 8'h3A, 8'h06, 8'h00, 8'h40, 8'h00, 8'h20}, // R2 half carry
        {5'd1,  1'b1, 8'h7F, 8'h00, 8'h00, 8'h80, 8'h00, 8'h2C}, // R2 R14 adc overflow
        {5'd2,  1'b0, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h00, 8'h20}, // R3 half borrow
        {5'd3,  1'b1, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h35}, // R3 sbc borrow in
        {5'd3,  1'b0, 8'h05, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00}, // R4 zero keeps Z=0
        {5'd4,  1'b1, 8'hF0, 8'h3C, 8'h00, 8'h30, 8'h00, 8'h21}, // R5 and
        {5'd5,  1'b0, 8'h80, 8'h01, 8'h00, 8'h81, 8'h00, 8'h14}, // R5 or
        {5'd6,  1'b1, 8'h55, 8'h55, 8'h00, 8'h00, 8'h00, 8'h23}, // R5 xor zero
        {5'd7,  1'b0, 8'h0F, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h15}, // R6 com
        {5'd8,  1'b0, 8'h80, 8'h00, 8'h00, 8'h80, 8'h00, 8'h0D}, // R7 neg 0x80
        {5'd8,  1'b0, 8'h01, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h35}, // R7 neg 1
        {5'd9,  1'b1, 8'h7F, 8'h00, 8'h00, 8'h80, 8'h00, 8'h2D}, // R8 inc overflow
        {5'd10, 1'b0, 8'h80, 8'h00, 8'h00, 8'h7F, 8'h00, 8'h18}, // R8 dec overflow
        {5'd10, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h23}, // R8 dec to zero
        {5'd11, 1'b0, 8'h81, 8'h00, 8'h00, 8'h02, 8'h00, 8'h19}, // R9 R11 lsl
        {5'd12, 1'b1, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h3B}, // R9 R11 lsr
        {5'd15, 1'b0, 8'h82, 8'h00, 8'h00, 8'hC1, 8'h00, 8'h0C}, // R9 R11 asr
        {5'd13, 1'b1, 8'h40, 8'h00, 8'h00, 8'h81, 8'h00, 8'h2C}, // R10 rol
        {5'd14, 1'b1, 8'h01, 8'h00, 8'h00, 8'h80, 8'h00, 8'h35}, // R10 ror C=1
        {5'd14, 1'b0, 8'h02, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00}, // R10 ror C=0
        {5'd16, 1'b1, 8'hA5, 8'h00, 8'h00, 8'h5A, 8'h00, 8'h35}, // R12 swap
        {5'd17, 1'b0, 8'hFF, 8'h01, 8'h7F, 8'h00, 8'h80, 8'h0C}, // R13 word overflow
        {5'd17, 1'b1, 8'hFF, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h23}, // R13 word carry
        {5'd18, 1'b0, 8'h00, 8'h3F, 8'h00, 8'hC1, 8'hFF, 8'h15}, // R13 word borrow
        {5'd18, 1'b1, 8'h00, 8'h01, 8'h80, 8'hFF, 8'h7F, 8'h38}, // R13 word overflow
        {5'd17, 1'b0, 8'h00, 8'hC2, 8'h00, 8'h02, 8'h00, 8'h00}, // R13 imm high bits
        {5'd25, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h35}  // R12 undefined code
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // drive at falling edge, sample combinational outputs 1 ns later,
    // sample the status register 1 ns after the following rising edge
    task automatic step(input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] hi,
                        input logic v);
        @(negedge clk);
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        pair_hi  = hi;
        op_valid = v;
        #1;
        cap_res  = result;
        cap_hi   = result_hi;
        cap_next = status_next;
        @(posedge clk);
        #1;
        cap_st   = status;
    endtask

    task automatic setup(input logic pre);
        if (pre) step(5'd0, 8'hFF, 8'hFF, 8'h00, 1'b1);
        else     step(5'd0, 8'h01, 8'h01, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset status", status, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [53:0] v;
            string tag;
            v = VECS[i];
            tag = $sformatf("vector %0d op %0d (R1..)", i, v[53:49]);
            setup(v[48]);
            step(v[53:49], v[47:40], v[39:32], v[31:24], 1'b1);
            chk({tag, " result"},      cap_res,  v[23:16]);
            chk({tag, " result_hi"},   cap_hi,   v[15:8]);
            chk({tag, " status_next"}, cap_next, v[7:0]);
            chk({tag, " status"},      cap_st,   v[7:0]);
        end

        // R1: without op_valid the status register holds its value
        setup(1'b1);
        step(5'd2, 8'h00, 8'h01, 8'h00, 1'b0);
        chk("R1 idle hold", cap_st, 8'h35);
        step(5'd11, 8'h00, 8'h00, 8'h00, 1'b0);
        chk("R1 idle hold shift", cap_st, 8'h35);

        // R4: zero result keeps a set Z across a chained subtract
        step(5'd0, 8'h00, 8'h00, 8'h00, 1'b1);
        chk("R4 chain setup", cap_st, 8'h02);
        step(5'd3, 8'h05, 8'h05, 8'h00, 1'b1);
        chk("R4 chain Z kept", cap_st, 8'h02);
        step(5'd3, 8'h06, 8'h05, 8'h00, 1'b1);
        chk("R4 chain Z cleared", cap_st, 8'h00);

        // R12: swap leaves every flag, including a set Z
        step(5'd0, 8'h00, 8'h00, 8'h00, 1'b1);
        step(5'd16, 8'h3C, 8'h00, 8'h00, 1'b1);
        chk("R12 swap result", cap_res, 8'hC3);
        chk("R12 swap status", cap_st, 8'h02);

        // R1: reset returns status to zero
        setup(1'b1);
        @(negedge clk);
        op_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset again", status, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule